// File: doc/BRIEF.md
# Prioritized Task Dispatcher with Preemptible Background Task

This block sequences work for a small co-processor. Up to eight task slots can raise requests, and each slot has an enable bit and a start vector. Whenever the engine is free, the dispatcher accepts the highest-priority request that is both flagged and enabled, and clears that flag. It then loads the slot's vector into the program counter with a one-cycle load strobe and shows the running slot on a one-hot output. A done strobe from the execution side ends the running task. Instruction fetch and execution sit outside the block and are represented only by `task_done` and `cur_pc`.

A background mode can be switched on. It removes the lowest-priority slot from the normal enable mask and turns that slot into a long-running background task. The background task takes its address from a vector of its own. It is started either by a software pulse or by a peripheral trigger, and a trigger-enable bit chooses which of the two is honoured. A foreground task may preempt the background task, which gives one level of nesting. When that happens, the background program counter is saved. After the foreground work is finished and nothing else is waiting, the saved address is reloaded. The background code can set a mask that makes a section of it uninterruptible. A second start of the background task while it is still alive sets a sticky overflow bit.

Top module: `task_dispatch`

## Requirements
- R1: With the engine free, the dispatcher accepts the lowest-indexed slot (index 0 = highest priority) whose flag and enable bit are both 1. One cycle later `pc_load` pulses for one cycle and `pc_val` equals that slot's vector, `vec_flat[i*AW +: AW]`. A flagged slot whose enable bit is 0 is not started and keeps its flag.
- R2: `run` is one-hot, with bit i set for slot i, or all zeros when no foreground task runs. A flag is cleared in the cycle its task is accepted. A new `req` pulse for the same slot in that same cycle leaves the flag set.
- R3: While a foreground task runs, no other task is started until `task_done` is seen.
- R4: While `bg_en` is 1, slot NTASK-1 is treated as disabled for foreground dispatch, whatever `en_mask` holds.
- R5: With `bg_en` = 1, the background task starts on `bg_sw_start` only when `bg_trig_en` = 0, and on `bg_hw_trig` only when `bg_trig_en` = 1. On a start with the engine free, `pc_val` is loaded with `bg_vec` and `bg_run` becomes 1.
- R6: A foreground task that preempts the running background task saves `cur_pc` into `bg_ret`. When that task ends and no task is pending, `pc_val` is loaded with `bg_ret` and `bg_run` returns to 1.
- R7: When a foreground task ends while another task is pending, the next task is accepted in the same cycle and the background task is not resumed.
- R8: While `bg_run` and `bg_mask` are both 1, no foreground task is started. `bg_mask_set` and `bg_mask_clr` act only while the background task executes, and the mask is cleared when the background task stops.
- R9: A background start that arrives while the background task is already alive sets `bg_ovf`. The bit stays set until a soft reset.
- R10: `task_done` while the background task executes stops it: `bg_run` falls and no address is loaded.
- R11: `soft_rst` returns the dispatcher to idle. It clears `run`, `bg_run`, `bg_mask`, `bg_ret` and `bg_ovf` and leaves the request flags intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset |
| req | input | NTASK | Request pulses, one per slot, that set flags |
| en_mask | input | NTASK | Per-slot enable bits |
| vec_flat | input | NTASK*AW | Per-slot start vectors, slot i at bits i*AW |
| bg_vec | input | AW | Background task start vector |
| bg_en | input | 1 | Background mode on |
| bg_trig_en | input | 1 | 1: peripheral trigger starts background; 0: software start |
| bg_sw_start | input | 1 | Software start pulse for the background task |
| bg_hw_trig | input | 1 | Peripheral trigger pulse for the background task |
| bg_mask_set | input | 1 | Make background uninterruptible |
| bg_mask_clr | input | 1 | Make background interruptible again |
| task_done | input | 1 | End of the current task |
| cur_pc | input | AW | Program counter of the execution side |
| flags | output | NTASK | Pending request flags |
| run | output | NTASK | One-hot running foreground slot |
| pc_load | output | 1 | One-cycle program counter load strobe |
| pc_val | output | AW | Address to load |
| bg_run | output | 1 | Background task executing |
| bg_mask | output | 1 | Background mask state |
| bg_ret | output | AW | Saved background return address |
| bg_ovf | output | 1 | Background retrigger overflow |

## Verification
The hardest state to reach is a preempted background task being resumed from a return address that differs from its start vector. Getting there needs the background task started, a distinct `cur_pc` applied, a foreground request that preempts it, and then a done strobe with nothing else pending. The stimulus also drives the masked variant. The mask is set and a request arrives and is held off. Then the mask is cleared with a new `cur_pc`, and the bench checks that the later preemption saved and restored that second address. Every expected load address is queued before the edge that produces it, so a missing, extra or misordered load is caught.

// File: rtl/task_dispatch.sv
module task_dispatch #(
  parameter int NTASK = 8,
  parameter int AW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [NTASK-1:0] req,
  input  logic [NTASK-1:0] en_mask,
  input  logic [NTASK*AW-1:0] vec_flat,
  input  logic [AW-1:0]    bg_vec,
  input  logic             bg_en,
  input  logic             bg_trig_en,
  input  logic             bg_sw_start,
  input  logic             bg_hw_trig,
  input  logic             bg_mask_set,
  input  logic             bg_mask_clr,
  input  logic             task_done,
  input  logic [AW-1:0]    cur_pc,
  output logic [NTASK-1:0] flags,
  output logic [NTASK-1:0] run,
  output logic             pc_load,
  output logic [AW-1:0]    pc_val,
  output logic             bg_run,
  output logic             bg_mask,
  output logic [AW-1:0]    bg_ret,
  output logic             bg_ovf
);
  localparam int BGS = NTASK - 1;

  logic             bg_active;
  logic [NTASK-1:0] eff_en, pend, grant;
  logic [AW-1:0]    gvec;

  assign eff_en = {en_mask[BGS] & ~bg_en, en_mask[BGS-1:0]};
  assign pend   = flags & eff_en;

  always_comb begin
    grant = '0;
    gvec  = '0;
    for (int i = NTASK - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        gvec     = vec_flat[i*AW +: AW];
      end
    end
  end

  wire fg_busy   = |run;
  wire fg_end    = task_done & fg_busy;
  wire bg_end    = task_done & ~fg_busy & bg_run;
  wire slot_free = ~fg_busy | fg_end;
  wire disp      = slot_free & (|pend) & ~(bg_run & bg_mask);
  wire bg_go     = bg_en & (bg_trig_en ? bg_hw_trig : bg_sw_start);
  wire bg_new    = bg_go & ~bg_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      run       <= '0;
      pc_load   <= 1'b0;
      pc_val    <= '0;
      bg_active <= 1'b0;
      bg_run    <= 1'b0;
      bg_mask   <= 1'b0;
      bg_ret    <= '0;
      bg_ovf    <= 1'b0;
    end else if (soft_rst) begin
      flags     <= flags | req;
      run       <= '0;
      pc_load   <= 1'b0;
      bg_active <= 1'b0;
      bg_run    <= 1'b0;
      bg_mask   <= 1'b0;
      bg_ret    <= '0;
      bg_ovf    <= 1'b0;
    end else begin
      pc_load <= 1'b0;
      flags   <= (flags & ~(disp ? grant : '0)) | req;
      if (bg_go && bg_active) bg_ovf <= 1'b1;

      if (bg_run) begin
        if (bg_mask_clr) bg_mask <= 1'b0;
        if (bg_mask_set) bg_mask <= 1'b1;
      end

      if (disp) begin
        run     <= grant;
        pc_load <= 1'b1;
        pc_val  <= gvec;
        if (bg_run) begin
          bg_ret <= cur_pc;
          bg_run <= 1'b0;
        end
      end else if (fg_end) begin
        run <= '0;
      end

      if (bg_new) begin
        bg_active <= 1'b1;
        if (slot_free && !disp) begin
          pc_load <= 1'b1;
          pc_val  <= bg_vec;
          bg_run  <= 1'b1;
        end else begin
          bg_ret <= bg_vec;
        end
      end else if (fg_end && !disp && bg_active) begin
        pc_load <= 1'b1;
        pc_val  <= bg_ret;
        bg_run  <= 1'b1;
      end

      if (bg_end) begin
        bg_active <= 1'b0;
        bg_run    <= 1'b0;
        bg_mask   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/task_dispatch_chk.sv
module task_dispatch_chk #(
  parameter int NTASK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic [NTASK-1:0] req,
  input logic             bg_en,
  input logic [NTASK-1:0] run,
  input logic [NTASK-1:0] flags,
  input logic             pc_load,
  input logic             bg_run,
  input logic             bg_mask,
  input logic             bg_ovf
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(run));

  p_accept_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run != '0 && run != $past(run)) |-> (pc_load && ((flags & run) == '0 || ($past(req) & run) != '0)));

  p_single_level_r3: assert property (@(posedge clk) disable iff (!rst_n) !(bg_run && (|run)));

  p_slot_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_en && $past(bg_en) && !$past(run[NTASK-1])) |-> !run[NTASK-1]);

  p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_run && bg_mask) |=> (run == '0));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bg_ovf) && !$past(soft_rst)) |-> bg_ovf);
endmodule

bind task_dispatch task_dispatch_chk #(.NTASK(NTASK)) u_chk (.*);

// File: tb/sim_task_dispatch.sv
`timescale 1ns/1ps
module sim_task_dispatch;
  localparam int NTASK = 8;
  localparam int AW    = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, soft_rst, bg_en, bg_trig_en, bg_sw_start, bg_hw_trig;
  logic bg_mask_set, bg_mask_clr, task_done;
  logic [NTASK-1:0] req, en_mask, flags, run;
  logic [NTASK*AW-1:0] vec_flat;
  logic [AW-1:0] bg_vec, cur_pc, pc_val, bg_ret;
  logic pc_load, bg_run, bg_mask, bg_ovf;

  task_dispatch #(.NTASK(NTASK), .AW(AW)) u0 (.*);

  int tests = 0, fails = 0;
  logic [AW-1:0] expq[$];
  bit finished = 0;

  function automatic logic [AW-1:0] tv(int i);
    return AW'(16'h1000 + i * 16'h0100);
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic nt(); @(negedge clk); endtask

  always @(negedge clk) begin
    if (rst_n && pc_load) begin
      if (expq.size() == 0) chk("R1 unexpected load", {16'h0, pc_val}, 32'hFFFF_FFFF);
      else chk("R1 load address", {16'h0, pc_val}, {16'h0, expq.pop_front()});
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NTASK; i++) vec_flat[i*AW +: AW] = tv(i);
    bg_vec = 16'hB000; cur_pc = 16'h0;
    rst_n = 0; soft_rst = 0; req = 0; en_mask = 8'hFF;
    bg_en = 0; bg_trig_en = 0; bg_sw_start = 0; bg_hw_trig = 0;
    bg_mask_set = 0; bg_mask_clr = 0; task_done = 0;
    repeat (3) nt();
    rst_n = 1;
    nt();
    chk("R2 reset run", run, 0);
    chk("R2 reset flags", flags, 0);
    chk("R10 reset bg_run", bg_run, 0);

    // R1 priority among two requests
    req = 8'h24; nt(); req = 0;
    chk("R2 flags set", flags, 8'h24);
    expq.push_back(tv(2)); nt();
    chk("R1 run slot 2", run, 8'h04);
    chk("R2 flag cleared", flags, 8'h20);
    // R3 no nesting while busy
    repeat (3) nt();
    chk("R3 still running", run, 8'h04);
    // R7 chained dispatch on done
    expq.push_back(tv(5)); task_done = 1; nt(); task_done = 0;
    chk("R7 chained run", run, 8'h20);
    task_done = 1; nt(); task_done = 0;
    chk("R1 idle after done", run, 0);

    // R1 disabled slot skipped
    en_mask = 8'hFE; req = 8'h03; nt(); req = 0;
    expq.push_back(tv(1)); nt();
    chk("R1 enabled slot picked", run, 8'h02);
    task_done = 1; nt(); task_done = 0;
    nt();
    chk("R1 disabled stays idle", run, 0);
    chk("R1 disabled keeps flag", flags, 8'h01);
    expq.push_back(tv(0)); en_mask = 8'hFF; nt(); nt();
    chk("R1 enabled later", run, 8'h01);
    task_done = 1; nt(); task_done = 0;

    // R2 request in the accept cycle keeps flag
    req = 8'h08; nt();
    expq.push_back(tv(3)); nt(); req = 0;
    chk("R2 accepted", run, 8'h08);
    chk("R2 flag re-set", flags, 8'h08);
    expq.push_back(tv(3)); task_done = 1; nt(); task_done = 0;
    chk("R2 rerun", run, 8'h08);
    task_done = 1; nt(); task_done = 0;
    chk("R2 idle", run, 0);

    // R4 background mode masks slot 7
    bg_en = 1; req = 8'h80; nt(); req = 0;
    nt(); nt();
    chk("R4 slot7 not run", run, 0);
    chk("R4 slot7 flagged", flags, 8'h80);

    // R5 software start ignored when trigger-enable is set
    bg_trig_en = 1; bg_sw_start = 1; nt(); bg_sw_start = 0; nt();
    chk("R5 sw ignored", bg_run, 0);
    bg_trig_en = 0; bg_sw_start = 1; expq.push_back(16'hB000); nt(); bg_sw_start = 0;
    chk("R5 bg running", bg_run, 1);
    // R9 retrigger overflow
    bg_sw_start = 1; nt(); bg_sw_start = 0;
    chk("R9 ovf set", bg_ovf, 1);
    nt();
    chk("R9 ovf sticky", bg_ovf, 1);

    // R6 preempt and resume
    cur_pc = 16'hB123; req = 8'h02; nt(); req = 0;
    expq.push_back(tv(1)); nt();
    chk("R6 preempt run", run, 8'h02);
    chk("R6 bg paused", bg_run, 0);
    chk("R6 saved pc", bg_ret, 16'hB123);
    expq.push_back(16'hB123); task_done = 1; nt(); task_done = 0;
    chk("R6 resumed", bg_run, 1);

    // R8 mask blocks preemption
    bg_mask_set = 1; nt(); bg_mask_set = 0;
    chk("R8 mask set", bg_mask, 1);
    req = 8'h01; nt(); req = 0; nt(); nt();
    chk("R8 blocked", run, 0);
    chk("R8 flag held", flags, 8'h81);
    cur_pc = 16'hB200; bg_mask_clr = 1; nt(); bg_mask_clr = 0;
    expq.push_back(tv(0)); nt();
    chk("R8 dispatched after clear", run, 8'h01);
    chk("R6 second save", bg_ret, 16'hB200);
    expq.push_back(16'hB200); task_done = 1; nt(); task_done = 0;
    chk("R6 second resume", bg_run, 1);

    // R10 background stops itself
    bg_mask_set = 1; nt(); bg_mask_set = 0;
    task_done = 1; nt(); task_done = 0;
    chk("R10 bg stopped", bg_run, 0);
    chk("R8 mask cleared on stop", bg_mask, 0);
    expq.push_back(16'hB000); bg_sw_start = 1; nt(); bg_sw_start = 0;
    chk("R10 restart", bg_run, 1);

    // R11 soft reset
    soft_rst = 1; nt(); soft_rst = 0;
    chk("R11 bg_run", bg_run, 0);
    chk("R11 bg_ret", bg_ret, 0);
    chk("R11 bg_ovf", bg_ovf, 0);
    chk("R11 run", run, 0);
    chk("R11 flags kept", flags, 8'h80);

    // R5 peripheral trigger
    bg_trig_en = 1; bg_hw_trig = 1; expq.push_back(16'hB000); nt(); bg_hw_trig = 0;
    chk("R5 hw start", bg_run, 1);
    nt(); nt();
    chk("R1 all loads seen", expq.size(), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule